// File: doc/BRIEF.md
# Bus Listener Byte Acceptor

This block is the receiving half of the three-wire handshake used on a byte-parallel instrument bus. It watches the talker's data-valid line, the eight inverted data lines and the attention, end and clear lines. It drives two open-collector enables: one pulls the not-ready line low and the other pulls the not-accepted line low. Each byte it takes is turned back to true polarity and passed downstream with two flags. One flag marks a command byte, meaning attention was asserted. The other marks the final byte of a message, meaning end was asserted.

Downstream transfer uses a valid/ready stream. A received byte sits in a one-entry slot with `out_valid` high. It stays there unchanged until `out_ready` is seen high on a clock edge. While the slot is full the acceptor keeps the not-ready line pulled low. The talker cannot start another byte, so back-pressure reaches the bus with no data lost. The controller can set `cmd_gate_en` to let a falling attention line pull not-ready low at once, through gates only. The handshake logic would otherwise react only after its synchronizers. All slow bus inputs pass through a two-stage synchronizer. Asserting the clear line aborts the handshake and holds both pulls asserted until clear is released. A byte already in the slot is kept.

Top module: `gpib_acceptor`

## Requirements
- R1: While reset is asserted, `pull_ready_low` and `pull_accept_low` are both 1 and `out_valid` is 0.
- R2: With the slot empty, no clear, and the valid line high, the acceptor announces readiness: `pull_ready_low` becomes 0 while `pull_accept_low` stays 1.
- R3: When the valid line is low during readiness, the acceptor captures the data lines and reasserts `pull_ready_low`. `out_byte` equals the bitwise inverse of the line levels (line low = bit 1).
- R4: `out_cmd` is 1 exactly when the attention line was low at capture, and `out_end` is 1 exactly when the end line was low at capture.
- R5: After a capture `pull_accept_low` goes to 0 until the valid line returns high, then goes back to 1. The two pulls are never both 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte`, `out_cmd` and `out_end` hold. A byte leaves on an edge where both are 1, and bytes leave in bus order.
- R7: While `out_valid` is 1, `pull_ready_low` stays 1 (no new byte is invited).
- R8: With `cmd_gate_en` = 1, a low attention line forces `pull_ready_low` to 1 in the same time step, with no clock edge needed.
- R9: With `cmd_gate_en` = 0, the attention line level has no effect on `pull_ready_low`.
- R10: A low clear line forces both pulls to 1 within three clock edges and blocks any capture while low. A byte already in the slot is kept. After release the handshake resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data_l | input | DATA_W | Data lines, active low |
| bus_valid_l | input | 1 | Talker's data-valid line, low = valid |
| bus_cmd_l | input | 1 | Attention line, low = command byte |
| bus_end_l | input | 1 | End line, low = last byte |
| bus_clear_l | input | 1 | Interface clear line, low = clear |
| cmd_gate_en | input | 1 | 1 = attention line drives the not-ready pull directly |
| pull_ready_low | output | 1 | 1 = pull the not-ready line low |
| pull_accept_low | output | 1 | 1 = pull the not-accepted line low |
| out_valid | output | 1 | Stream valid: a received byte is held |
| out_ready | input | 1 | Stream ready from downstream |
| out_byte | output | DATA_W | Received byte, true polarity |
| out_cmd | output | 1 | Byte arrived with attention asserted |
| out_end | output | 1 | Byte arrived with end asserted |

## Verification
A handshake state that went wrong shows on the two pull outputs within a clock or two. Both pulls released at once is a bus protocol violation. A pull stuck asserted shows up as a hung talker in the bench's bounded waits. A wrong slot state shows either as a byte reaching the stream twice or out of order, which the scoreboard catches at the next transfer, or as readiness announced while the slot is full, which shows on `pull_ready_low` at the same edge. Faults in the synchronizer or polarity show on the first captured byte as a bit-inverted value or a flag error.

// File: rtl/gpib_acc_pkg.sv
package gpib_acc_pkg;
  // Handshake phase of the acceptor.
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,  // not ready, data not accepted
    ACC_OPEN = 2'd1,  // ready announced, waiting for valid
    ACC_TAKE = 2'd2   // byte taken, accepted released
  } acc_state_t;

  // Number of control lines carried beside the data lines.
  localparam int CTRL_LINES = 4;
endpackage

// File: rtl/gpib_acc_sync.sv
module gpib_acc_sync #(
  parameter int WIDTH   = 12,
  parameter int STAGES  = 2,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_LEVEL}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpib_acc_fsm.sv
module gpib_acc_fsm
  import gpib_acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dav_act,
  input  logic clear_act,
  input  logic slot_busy,
  output logic hold_ready,
  output logic hold_accept,
  output logic capture
);
  acc_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ACC_HOLD: if (!slot_busy && !dav_act) state_nx = ACC_OPEN;
      ACC_OPEN: if (dav_act)                state_nx = ACC_TAKE;
      ACC_TAKE: if (!dav_act)               state_nx = ACC_HOLD;
      default:                              state_nx = ACC_HOLD;
    endcase
    if (clear_act) state_nx = ACC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ACC_HOLD;
    else        state <= state_nx;
  end

  assign capture     = (state == ACC_OPEN) && dav_act && !clear_act;
  assign hold_ready  = (state != ACC_OPEN);
  assign hold_accept = (state != ACC_TAKE);
endmodule

// File: rtl/gpib_acc_slot.sv
module gpib_acc_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              load_cmd,
  input  logic              load_end,
  output logic              valid,
  input  logic              ready,
  output logic [DATA_W-1:0] data,
  output logic              cmd,
  output logic              last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      cmd   <= 1'b0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_byte;
      cmd   <= load_cmd;
      last  <= load_end;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpib_acceptor.sv
module gpib_acceptor
  import gpib_acc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data_l,
  input  logic              bus_valid_l,
  input  logic              bus_cmd_l,
  input  logic              bus_end_l,
  input  logic              bus_clear_l,
  input  logic              cmd_gate_en,
  output logic              pull_ready_low,
  output logic              pull_accept_low,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_cmd,
  output logic              out_end
);
  localparam int LINES_W = DATA_W + CTRL_LINES;

  logic [LINES_W-1:0] lines_s;
  logic [DATA_W-1:0]  data_s;
  logic dav_act, cmd_act, end_act, clear_act;
  logic fsm_hold_ready, capture;

  gpib_acc_sync #(.WIDTH(LINES_W), .STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({bus_data_l, bus_valid_l, bus_cmd_l, bus_end_l, bus_clear_l}),
    .q   (lines_s)
  );

  assign data_s    = lines_s[LINES_W-1:CTRL_LINES];
  assign dav_act   = ~lines_s[3];
  assign cmd_act   = ~lines_s[2];
  assign end_act   = ~lines_s[1];
  assign clear_act = ~lines_s[0];

  gpib_acc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dav_act     (dav_act),
    .clear_act   (clear_act),
    .slot_busy   (out_valid),
    .hold_ready  (fsm_hold_ready),
    .hold_accept (pull_accept_low),
    .capture     (capture)
  );

  gpib_acc_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (capture),
    .load_byte (~data_s),
    .load_cmd  (cmd_act),
    .load_end  (end_act),
    .valid     (out_valid),
    .ready     (out_ready),
    .data      (out_byte),
    .cmd       (out_cmd),
    .last      (out_end)
  );

  // Fast path: a falling attention line holds off the talker before the
  // synchronized logic can react.
  assign pull_ready_low = fsm_hold_ready | (cmd_gate_en & ~bus_cmd_l);
endmodule

// File: rtl/gpib_acceptor_chk.sv
module gpib_acceptor_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cmd_l,
  input logic              cmd_gate_en,
  input logic              clear_act,
  input logic              pull_ready_low,
  input logic              pull_accept_low,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_byte,
  input logic              out_cmd,
  input logic              out_end
);
  // R5: never both lines released
  p_never_both_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pull_ready_low || pull_accept_low);

  // R3: a fresh byte coincides with not-ready held and accepted released
  p_capture_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (pull_ready_low && !pull_accept_low));

  // R6: held byte is stable under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) &&
                                   $stable(out_cmd) && $stable(out_end)));

  // R7: full slot keeps the talker waiting
  p_no_invite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pull_ready_low);

  // R8: gated attention path
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_gate_en && !bus_cmd_l) |-> pull_ready_low);

  // R10: clear forces both pulls
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_act |=> (pull_ready_low && pull_accept_low));
endmodule

bind gpib_acceptor gpib_acceptor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_cmd_l       (bus_cmd_l),
  .cmd_gate_en     (cmd_gate_en),
  .clear_act       (clear_act),
  .pull_ready_low  (pull_ready_low),
  .pull_accept_low (pull_accept_low),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_byte        (out_byte),
  .out_cmd         (out_cmd),
  .out_end         (out_end)
);

// File: tb/test_gpib_acceptor.sv
`timescale 1ns/1ps
module test_gpib_acceptor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data_l = 8'hFF;
  logic       bus_valid_l = 1'b1, bus_cmd_l = 1'b1, bus_end_l = 1'b1, bus_clear_l = 1'b1;
  logic       cmd_gate_en = 1'b0;
  logic       pull_ready_low, pull_accept_low;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_byte;
  logic       out_cmd, out_end;

  int checks = 0, fails = 0;
  int rdy_mode = 0;
  bit done = 0;
  logic [9:0] exp_q[$];

  always #10 clk = ~clk;

  gpib_acceptor i_gpib_acceptor (
    .clk(clk), .rst_n(rst_n), .bus_data_l(bus_data_l), .bus_valid_l(bus_valid_l),
    .bus_cmd_l(bus_cmd_l), .bus_end_l(bus_end_l), .bus_clear_l(bus_clear_l),
    .cmd_gate_en(cmd_gate_en), .pull_ready_low(pull_ready_low),
    .pull_accept_low(pull_accept_low), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_cmd(out_cmd), .out_end(out_end));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Bounded wait for a pull output to reach a level.
  task automatic wait_pull(input bit which_accept, input logic lvl, input string req);
    int n = 0;
    while (((which_accept ? pull_accept_low : pull_ready_low) !== lvl) && n < 60) begin
      @(negedge clk); n++;
    end
    chk(n < 60, req, which_accept ? "accept pull level" : "ready pull level",
        which_accept ? pull_accept_low : pull_ready_low, lvl);
  endtask

  // Talker model and scoreboard driver.
  task automatic send(input logic [7:0] b, input bit is_cmd, input bit is_end);
    wait_pull(0, 1'b0, "R2");
    chk(pull_accept_low === 1'b1, "R2", "accept held while ready", pull_accept_low, 1);
    exp_q.push_back({is_cmd, is_end, b});
    @(negedge clk); #2;
    bus_data_l = ~b; bus_cmd_l = ~is_cmd; bus_end_l = ~is_end;
    @(negedge clk); #2;
    bus_valid_l = 1'b0;
    wait_pull(1, 1'b0, "R5");
    chk(pull_ready_low === 1'b1, "R3", "ready pulled after capture", pull_ready_low, 1);
    @(negedge clk); #2;
    bus_valid_l = 1'b1;
    bus_data_l = 8'hFF; bus_cmd_l = 1'b1; bus_end_l = 1'b1;
    wait_pull(1, 1'b1, "R5");
  endtask

  // Downstream ready pattern.
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt++;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cnt % 3) == 0;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // Monitor: pops expected items on each transfer (R3, R4, R6).
  initial begin
    logic [9:0] e;
    logic [9:0] prev = '0;
    bit prev_held = 0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (prev_held)
          chk({out_cmd, out_end, out_byte} === prev, "R6", "held byte stable",
              {out_cmd, out_end, out_byte}, prev);
        if (out_ready) begin
          if (exp_q.size() == 0) begin
            chk(0, "R6", "unexpected byte", out_byte, 0);
          end else begin
            e = exp_q.pop_front();
            chk(out_byte === e[7:0], "R3", "byte value", out_byte, e[7:0]);
            chk({out_cmd, out_end} === e[9:8], "R4", "cmd/end flags",
                {out_cmd, out_end}, e[9:8]);
          end
          prev_held = 0;
        end else begin
          prev = {out_cmd, out_end, out_byte};
          prev_held = 1;
        end
      end else prev_held = 0;
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pull_ready_low === 1 && pull_accept_low === 1, "R1", "pulls in reset",
        {pull_ready_low, pull_accept_low}, 2'b11);
    chk(out_valid === 1'b0, "R1", "valid in reset", out_valid, 0);
    #2 rst_n = 1'b1;

    // Main flow, downstream always ready.
    send(8'hA5, 0, 0);
    send(8'h3F, 1, 0);
    send(8'h00, 0, 0);
    send(8'hFF, 0, 1);
    send(8'h24, 1, 1);

    // R7: back-pressure holds the talker off.
    rdy_mode = 2;
    send(8'h5A, 0, 0);
    repeat (8) @(negedge clk);
    chk(pull_ready_low === 1'b1, "R7", "no readiness while slot full", pull_ready_low, 1);
    chk(out_valid === 1'b1 && out_byte === 8'h5A, "R6", "byte held",
        {out_valid, out_byte}, {1'b1, 8'h5A});
    rdy_mode = 0;

    // Intermittent downstream ready.
    rdy_mode = 1;
    for (int i = 0; i < 6; i++) send(8'(i * 37 + 3), i[0], i[1]);
    rdy_mode = 0;
    wait_pull(0, 1'b0, "R2");

    // R8: gated attention path acts without a clock edge.
    @(negedge clk); #3;
    cmd_gate_en = 1'b1;
    bus_cmd_l = 1'b0;
    #1 chk(pull_ready_low === 1'b1, "R8", "attention forces not-ready", pull_ready_low, 1);
    bus_cmd_l = 1'b1;
    #1 chk(pull_ready_low === 1'b0, "R8", "release follows attention", pull_ready_low, 0);
    cmd_gate_en = 1'b0;

    // R9: gate off, attention has no effect on the ready pull.
    bus_cmd_l = 1'b0;
    #1 chk(pull_ready_low === 1'b0, "R9", "ungated attention immediate", pull_ready_low, 0);
    repeat (6) @(negedge clk);
    chk(pull_ready_low === 1'b0, "R9", "ungated attention later", pull_ready_low, 0);
    bus_cmd_l = 1'b1;

    // R10: clear while idle blocks capture.
    @(negedge clk); #2;
    bus_clear_l = 1'b0;
    repeat (3) @(negedge clk);
    chk(pull_ready_low === 1 && pull_accept_low === 1, "R10", "pulls under clear",
        {pull_ready_low, pull_accept_low}, 2'b11);
    bus_data_l = ~8'h11; bus_valid_l = 1'b0;
    repeat (6) @(negedge clk);
    chk(out_valid === 1'b0, "R10", "no capture under clear", out_valid, 0);
    bus_valid_l = 1'b1; bus_data_l = 8'hFF;
    repeat (3) @(negedge clk);
    bus_clear_l = 1'b1;
    send(8'h81, 0, 0);

    // R10: clear in the middle of a byte; slot keeps the captured byte.
    rdy_mode = 2;
    wait_pull(0, 1'b0, "R2");
    exp_q.push_back({1'b0, 1'b0, 8'hC3});
    @(negedge clk); #2;
    bus_data_l = ~8'hC3; bus_valid_l = 1'b0;
    wait_pull(1, 1'b0, "R5");
    bus_clear_l = 1'b0;
    repeat (3) @(negedge clk);
    chk(pull_ready_low === 1 && pull_accept_low === 1, "R10", "abort mid-byte",
        {pull_ready_low, pull_accept_low}, 2'b11);
    chk(out_valid === 1'b1 && out_byte === 8'hC3, "R10", "slot kept over clear",
        {out_valid, out_byte}, {1'b1, 8'hC3});
    bus_valid_l = 1'b1; bus_data_l = 8'hFF;
    repeat (3) @(negedge clk);
    bus_clear_l = 1'b1;
    rdy_mode = 0;
    send(8'h7E, 1, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "all bytes delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule